// File: doc/BRIEF.md
# D-PHY Receiver Bring-Up Sequencer

This block brings a D-PHY receiver and the CSI-2 host logic behind it out of reset. It takes two inputs: a link rate in Mbps and a count of active data lanes. A start request first writes the lane configuration. It then drives the PHY power and reset pins through a fixed, timed order. Part of that order is a pulse on the test-clear pin. The block turns the link rate into a 6-bit frequency-range code and programs it into the PHY through a request/acknowledge transaction port. Last, it releases the controller resets and reports ready once a settling time has passed.

Every wait is a minimum time in microseconds. Each one is turned into system clock cycles from a clock-frequency parameter and rounded up. A stop request can arrive at any time. It drops the link back to a single lane, puts the PHY and the controller back into reset, and clears ready.

Top module: `dphy_bringup`

## Requirements
- R1: While reset is held, every output is low. This covers the PHY pins, txnReq, ready, rangeErr, laneCfg (0) and ctrlRstN (all zeros).
- R2: A start sampled in the idle or ready state loads laneCfg with laneCount minus 1 on that edge. This happens one cycle before any PHY pin changes.
- R3: One edge after the start edge, phyRstz and phyShutdownz go to 0, testClk goes to 1, testEn goes to 0 and testClr goes to 1. testClr stays high for CLR cycles, where CLR is 15 us in clocks rounded up (3000 at the defaults). It then stays low for another CLR cycles before the transaction request.
- R4: The range code comes from a table of 39 ascending rate bounds. The selected entry is the first one whose bound is at or above the rate; a rate above every bound takes the last entry. Sample entries (bound: code): 89: 0x00, 99: 0x10, 109: 0x20, 129: 0x01, 449: 0x06, 999: 0x1A, 1500: 0x3C.
- R5: txnReq is held high until txnAck is sampled high, and falls on that edge. While it is high, txnCode is 0x44 and txnData is the range code shifted left by one bit (bit 0 is 0).
- R6: phyShutdownz rises SET cycles after the acknowledge edge, where SET is 5 us rounded up (1000 at the defaults). phyRstz rises SET cycles after that, and ctrlRstN becomes all ones on the next edge.
- R7: ready rises HOLD cycles after ctrlRstN becomes all ones, where HOLD is 10 us rounded up (2000 at the defaults). It stays high until a stop or a new start.
- R8: rangeErr is loaded at each accepted start. It is 1 if the rate is below 80 or above 1500, and 0 otherwise. An out-of-range rate still runs the full sequence with the clamped table entry.
- R9: A start that arrives between an accepted start and ready has no effect on any output.
- R10: A stop sampled in any state returns the block to idle on that edge. laneCfg goes to 0, ctrlRstN to all zeros, and ready, txnReq, phyRstz, phyShutdownz and testClr to 0. Stop wins over a start or an acknowledge sampled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin the bring-up sequence |
| stopReq | input | 1 | Abort and return the link to its reset state |
| rateMbps | input | 11 | Link rate in Mbps |
| laneCount | input | LANE_W+1 (3) | Active data lanes, 1 to MAX_LANES |
| txnAck | input | 1 | Acknowledge from the transaction master |
| laneCfg | output | LANE_W (2) | Lane configuration value (lanes minus one) |
| ctrlRstN | output | CTRL_RST_W (32) | Controller reset word, all ones when released |
| phyRstz | output | 1 | PHY reset, active low |
| phyShutdownz | output | 1 | PHY shutdown, active low |
| testClk | output | 1 | PHY test clock level |
| testEn | output | 1 | PHY test enable level |
| testClr | output | 1 | PHY test clear |
| txnReq | output | 1 | Transaction request to the test interface |
| txnCode | output | 8 | Test code of the transaction |
| txnData | output | 8 | Data byte of the transaction |
| rangeErr | output | 1 | Rate outside 80 to 1500 Mbps |
| ready | output | 1 | Bring-up complete |

## Verification
Stop can land in the same cycle as one of two other events: a start request, or the transaction acknowledge.

The bench provokes the first case by raising start and stop together while the block is idle. It provokes the second by issuing the stop on the very clock where its zero-delay responder returns the acknowledge.

A behavioural timeline model gives stop priority and is compared with every output on every clock. For the acknowledge case, the bench also confirms that shutdown is not released after the settle time that acknowledge would have started.

// File: rtl/dphy_bringup_pkg.sv
package dphy_bringup_pkg;

  localparam int RATE_W = 11;
  localparam int FREQ_ENTRIES = 39;
  localparam logic [RATE_W-1:0] RATE_LOW = RATE_W'(80);
  localparam logic [RATE_W-1:0] RATE_HIGH = RATE_W'(1500);
  localparam logic [7:0] RANGE_TEST_CODE = 8'h44;

  typedef enum logic [1:0] {
    WAIT_CLR,
    WAIT_SETTLE,
    WAIT_HOLD
  } waitSel_e;

  typedef struct packed {
    logic     park;
    logic     capture;
    logic     ctrlRelease;
    logic     loadWait;
    waitSel_e waitSel;
  } seqStrobe_t;

  localparam logic [RATE_W-1:0] RANGE_BOUND [FREQ_ENTRIES] = '{
    89, 99, 109, 129, 139, 149, 169, 179, 199, 219,
    239, 249, 269, 299, 329, 359, 399, 449, 499, 549,
    599, 649, 699, 749, 799, 849, 899, 949, 999, 1049,
    1099, 1149, 1199, 1249, 1299, 1349, 1399, 1449, 1500
  };

  localparam logic [5:0] RANGE_CODE [FREQ_ENTRIES] = '{
    6'h00, 6'h10, 6'h20, 6'h01, 6'h11, 6'h21, 6'h02, 6'h12, 6'h22, 6'h03,
    6'h13, 6'h23, 6'h04, 6'h14, 6'h05, 6'h15, 6'h25, 6'h06, 6'h16, 6'h07,
    6'h17, 6'h08, 6'h18, 6'h09, 6'h19, 6'h29, 6'h39, 6'h0A, 6'h1A, 6'h2A,
    6'h3A, 6'h0B, 6'h1B, 6'h2B, 6'h3B, 6'h0C, 6'h1C, 6'h2C, 6'h3C
  };

  // First bound at or above the rate wins; beyond the top bound the last entry applies.
  function automatic logic [5:0] rangeLookup(input logic [RATE_W-1:0] rate);
    logic [5:0] code;
    code = RANGE_CODE[FREQ_ENTRIES-1];
    for (int i = FREQ_ENTRIES - 1; i >= 0; i--) begin
      if (rate <= RANGE_BOUND[i]) code = RANGE_CODE[i];
    end
    return code;
  endfunction

endpackage

// File: rtl/dphy_bringup_dp.sv
module dphy_bringup_dp
  import dphy_bringup_pkg::*;
#(
  parameter int LANE_W = 2,
  parameter int CTRL_RST_W = 32,
  parameter int CLR_CYC = 3000,
  parameter int SETTLE_CYC = 1000,
  parameter int HOLD_CYC = 2000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobe_t            strobe,
  input  logic [RATE_W-1:0]     rateIn,
  input  logic [LANE_W:0]       laneCountIn,
  output logic                  waitDone,
  output logic [LANE_W-1:0]     laneCfg,
  output logic [CTRL_RST_W-1:0] ctrlRstN,
  output logic                  rangeErr,
  output logic [7:0]            progData
);

  localparam int MAX_A = (CLR_CYC > SETTLE_CYC) ? CLR_CYC : SETTLE_CYC;
  localparam int MAX_CYC = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int WAIT_W = $clog2(MAX_CYC + 1);

  logic [WAIT_W-1:0] timer;
  logic [WAIT_W-1:0] waitLen;
  logic [RATE_W-1:0] rateReg;

  always_comb begin
    case (strobe.waitSel)
      WAIT_CLR:    waitLen = WAIT_W'(CLR_CYC - 1);
      WAIT_SETTLE: waitLen = WAIT_W'(SETTLE_CYC - 1);
      default:     waitLen = WAIT_W'(HOLD_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer    <= '0;
      laneCfg  <= '0;
      ctrlRstN <= '0;
      rangeErr <= 1'b0;
      rateReg  <= '0;
    end else begin
      if (strobe.loadWait) timer <= waitLen;
      else if (timer != '0) timer <= timer - 1'b1;

      if (strobe.park) begin
        laneCfg  <= '0;
        ctrlRstN <= '0;
      end else if (strobe.capture) begin
        laneCfg  <= LANE_W'(laneCountIn - 1'b1);
        rateReg  <= rateIn;
        rangeErr <= (rateIn < RATE_LOW) || (rateIn > RATE_HIGH);
        ctrlRstN <= '0;
      end else if (strobe.ctrlRelease) begin
        ctrlRstN <= '1;
      end
    end
  end

  assign waitDone = (timer == '0);
  assign progData = {rangeLookup(rateReg), 1'b0};

endmodule

// File: rtl/dphy_bringup_ctrl.sv
module dphy_bringup_ctrl
  import dphy_bringup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       stopReq,
  input  logic       txnAck,
  input  logic       waitDone,
  output seqStrobe_t strobe,
  output logic       phyRstz,
  output logic       phyShutdownz,
  output logic       testClk,
  output logic       testEn,
  output logic       testClr,
  output logic       txnReq,
  output logic       ready
);

  typedef enum logic [3:0] {
    S_IDLE, S_LANES, S_CLR_HI, S_CLR_LO, S_PROG,
    S_SETTLE, S_SHUT_OFF, S_CTRL, S_HOLD, S_READY
  } seqState_e;

  seqState_e state, nxt;

  always_comb begin
    strobe = '0;
    nxt = state;
    if (stopReq) begin
      strobe.park = 1'b1;
      nxt = S_IDLE;
    end else begin
      case (state)
        S_IDLE, S_READY: if (startReq) begin
          strobe.capture = 1'b1;
          nxt = S_LANES;
        end
        S_LANES: begin
          strobe.loadWait = 1'b1;
          strobe.waitSel = WAIT_CLR;
          nxt = S_CLR_HI;
        end
        S_CLR_HI: if (waitDone) begin
          strobe.loadWait = 1'b1;
          strobe.waitSel = WAIT_CLR;
          nxt = S_CLR_LO;
        end
        S_CLR_LO: if (waitDone) nxt = S_PROG;
        S_PROG: if (txnAck) begin
          strobe.loadWait = 1'b1;
          strobe.waitSel = WAIT_SETTLE;
          nxt = S_SETTLE;
        end
        S_SETTLE: if (waitDone) begin
          strobe.loadWait = 1'b1;
          strobe.waitSel = WAIT_SETTLE;
          nxt = S_SHUT_OFF;
        end
        S_SHUT_OFF: if (waitDone) nxt = S_CTRL;
        S_CTRL: begin
          strobe.ctrlRelease = 1'b1;
          strobe.loadWait = 1'b1;
          strobe.waitSel = WAIT_HOLD;
          nxt = S_HOLD;
        end
        S_HOLD: if (waitDone) nxt = S_READY;
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= S_IDLE;
      phyRstz      <= 1'b0;
      phyShutdownz <= 1'b0;
      testClk      <= 1'b0;
      testEn       <= 1'b0;
      testClr      <= 1'b0;
      txnReq       <= 1'b0;
      ready        <= 1'b0;
    end else begin
      state <= nxt;
      if (stopReq) begin
        phyRstz      <= 1'b0;
        phyShutdownz <= 1'b0;
        testClr      <= 1'b0;
        txnReq       <= 1'b0;
        ready        <= 1'b0;
      end else if (nxt != state) begin
        case (nxt)
          S_LANES:    ready <= 1'b0;
          S_CLR_HI: begin
            phyRstz      <= 1'b0;
            phyShutdownz <= 1'b0;
            testClk      <= 1'b1;
            testEn       <= 1'b0;
            testClr      <= 1'b1;
          end
          S_CLR_LO:   testClr <= 1'b0;
          S_PROG:     txnReq <= 1'b1;
          S_SETTLE:   txnReq <= 1'b0;
          S_SHUT_OFF: phyShutdownz <= 1'b1;
          S_CTRL:     phyRstz <= 1'b1;
          S_READY:    ready <= 1'b1;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dphy_bringup.sv
module dphy_bringup
  import dphy_bringup_pkg::*;
#(
  parameter int CLK_KHZ = 200_000,
  parameter int MAX_LANES = 4,
  parameter int CTRL_RST_W = 32,
  parameter int CLR_US = 15,
  parameter int SETTLE_US = 5,
  parameter int HOLD_US = 10,
  localparam int LANE_W = $clog2(MAX_LANES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startReq,
  input  logic                  stopReq,
  input  logic [RATE_W-1:0]     rateMbps,
  input  logic [LANE_W:0]       laneCount,
  input  logic                  txnAck,
  output logic [LANE_W-1:0]     laneCfg,
  output logic [CTRL_RST_W-1:0] ctrlRstN,
  output logic                  phyRstz,
  output logic                  phyShutdownz,
  output logic                  testClk,
  output logic                  testEn,
  output logic                  testClr,
  output logic                  txnReq,
  output logic [7:0]            txnCode,
  output logic [7:0]            txnData,
  output logic                  rangeErr,
  output logic                  ready
);

  // Minimum times rounded up to whole clocks.
  localparam int CLR_CYC = (CLR_US * CLK_KHZ + 999) / 1000;
  localparam int SETTLE_CYC = (SETTLE_US * CLK_KHZ + 999) / 1000;
  localparam int HOLD_CYC = (HOLD_US * CLK_KHZ + 999) / 1000;

  seqStrobe_t strobe;
  logic waitDone;

  dphy_bringup_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .txnAck(txnAck), .waitDone(waitDone), .strobe(strobe),
    .phyRstz(phyRstz), .phyShutdownz(phyShutdownz), .testClk(testClk),
    .testEn(testEn), .testClr(testClr), .txnReq(txnReq), .ready(ready)
  );

  dphy_bringup_dp #(
    .LANE_W(LANE_W), .CTRL_RST_W(CTRL_RST_W), .CLR_CYC(CLR_CYC),
    .SETTLE_CYC(SETTLE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rateIn(rateMbps),
    .laneCountIn(laneCount), .waitDone(waitDone), .laneCfg(laneCfg),
    .ctrlRstN(ctrlRstN), .rangeErr(rangeErr), .progData(txnData)
  );

  assign txnCode = RANGE_TEST_CODE;

endmodule

// File: rtl/dphy_bringup_chk.sv
module dphy_bringup_chk #(
  parameter int LANE_W = 2,
  parameter int CTRL_RST_W = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  stopReq,
  input logic                  txnAck,
  input logic [LANE_W-1:0]     laneCfg,
  input logic [CTRL_RST_W-1:0] ctrlRstN,
  input logic                  phyRstz,
  input logic                  phyShutdownz,
  input logic                  testClr,
  input logic                  txnReq,
  input logic [7:0]            txnData,
  input logic                  ready
);

  p_clr_in_reset_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(testClr) |-> !phyRstz && !phyShutdownz);

  p_prog_after_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txnReq) |-> !testClr && !phyShutdownz && !phyRstz);

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    txnReq && !txnAck && !stopReq |=> txnReq);

  p_data_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    txnReq && !$rose(txnReq) |-> $stable(txnData));

  p_shut_before_rst_r6: assert property (@(posedge clk) disable iff (!rstN)
    phyRstz |-> phyShutdownz);

  p_ready_released_r7: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (ctrlRstN == '1) && phyRstz);

  p_stop_parks_r10: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> !ready && !txnReq && (laneCfg == '0) && (ctrlRstN == '0) && !phyRstz);

endmodule

bind dphy_bringup dphy_bringup_chk #(.LANE_W(LANE_W), .CTRL_RST_W(CTRL_RST_W)) u_chk (
  .clk(clk), .rstN(rstN), .stopReq(stopReq), .txnAck(txnAck), .laneCfg(laneCfg),
  .ctrlRstN(ctrlRstN), .phyRstz(phyRstz), .phyShutdownz(phyShutdownz),
  .testClr(testClr), .txnReq(txnReq), .txnData(txnData), .ready(ready)
);

// File: tb/sim_dphy_bringup.sv
`timescale 1ns/1ps
module sim_dphy_bringup;

  localparam int W_CLR = 3000;
  localparam int W_SET = 1000;
  localparam int W_HOLD = 2000;
  localparam int P_IDLE = 0, P_INIT = 1, P_CLRH = 2, P_CLRL = 3, P_PROG = 4,
                 P_SET = 5, P_SHUT = 6, P_CREL = 7, P_HOLD = 8, P_READY = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, stopReq = 1'b0, txnAck = 1'b0;
  logic [10:0] rateMbps = '0;
  logic [2:0] laneCount = 3'd1;
  logic [1:0] laneCfg;
  logic [31:0] ctrlRstN;
  logic phyRstz, phyShutdownz, testClk, testEn, testClr, txnReq, rangeErr, ready;
  logic [7:0] txnCode, txnData;

  int checks = 0, fails = 0;
  int ackDelay = 0, ackWait = 0;
  bit cmpOn = 0, finished = 0;

  // expected state of the behavioural model
  int mPhase = P_IDLE, mCnt = 0, mRate = 0;
  int eLane = 0, eCtrl = 0, eErr = 0, eReady = 0, eReq = 0, eData = 0;
  int eRstz = 0, eShut = 0, eTclk = 0, eTen = 0, eClr = 0;

  always #2.5 clk = ~clk;

  dphy_bringup u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .rateMbps(rateMbps), .laneCount(laneCount), .txnAck(txnAck),
    .laneCfg(laneCfg), .ctrlRstN(ctrlRstN), .phyRstz(phyRstz),
    .phyShutdownz(phyShutdownz), .testClk(testClk), .testEn(testEn),
    .testClr(testClr), .txnReq(txnReq), .txnCode(txnCode), .txnData(txnData),
    .rangeErr(rangeErr), .ready(ready)
  );

  function automatic int expCode(int rate);
    int bounds[7] = '{89, 99, 109, 129, 449, 999, 1500};
    int codes[7] = '{'h00, 'h10, 'h20, 'h01, 'h06, 'h1A, 'h3C};
    for (int i = 0; i < 7; i++) if (rate <= bounds[i]) return codes[i];
    return codes[6];
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // transaction responder: acknowledges after ackDelay cycles of request
  always @(negedge clk) begin
    if (txnReq && !txnAck) begin
      if (ackWait >= ackDelay) txnAck = 1'b1;
      else ackWait++;
    end else begin
      txnAck = 1'b0;
      ackWait = 0;
    end
  end

  // behavioural timeline model, stepped on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = P_IDLE; eLane = 0; eCtrl = 0; eErr = 0; eReady = 0; eReq = 0;
      eRstz = 0; eShut = 0; eTclk = 0; eTen = 0; eClr = 0;
    end else if (stopReq) begin
      mPhase = P_IDLE; eLane = 0; eCtrl = 0; eReady = 0; eReq = 0;
      eRstz = 0; eShut = 0; eClr = 0;
    end else begin
      case (mPhase)
        P_IDLE, P_READY: if (startReq) begin
          eLane = int'(laneCount) - 1; mRate = int'(rateMbps);
          eErr = (mRate < 80 || mRate > 1500) ? 1 : 0;
          eCtrl = 0; eReady = 0; mPhase = P_INIT;
        end
        P_INIT: begin
          eRstz = 0; eShut = 0; eTclk = 1; eTen = 0; eClr = 1;
          mCnt = W_CLR; mPhase = P_CLRH;
        end
        P_CLRH: begin
          mCnt--;
          if (mCnt == 0) begin eClr = 0; mCnt = W_CLR; mPhase = P_CLRL; end
        end
        P_CLRL: begin
          mCnt--;
          if (mCnt == 0) begin eReq = 1; eData = expCode(mRate) * 2; mPhase = P_PROG; end
        end
        P_PROG: if (txnAck) begin eReq = 0; mCnt = W_SET; mPhase = P_SET; end
        P_SET: begin
          mCnt--;
          if (mCnt == 0) begin eShut = 1; mCnt = W_SET; mPhase = P_SHUT; end
        end
        P_SHUT: begin
          mCnt--;
          if (mCnt == 0) begin eRstz = 1; mPhase = P_CREL; end
        end
        P_CREL: begin eCtrl = 1; mCnt = W_HOLD; mPhase = P_HOLD; end
        P_HOLD: begin
          mCnt--;
          if (mCnt == 0) begin eReady = 1; mPhase = P_READY; end
        end
        default: mPhase = P_IDLE;
      endcase
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (cmpOn) begin
      check("R2", "laneCfg", int'(laneCfg), eLane);
      check("R3", "testClr", int'(testClr), eClr);
      check("R3", "testClk", int'(testClk), eTclk);
      check("R3", "testEn", int'(testEn), eTen);
      check("R5", "txnReq", int'(txnReq), eReq);
      if (eReq == 1) begin
        check("R4", "txnData", int'(txnData), eData);
        check("R5", "txnCode", int'(txnCode), 'h44);
      end
      check("R6", "phyShutdownz", int'(phyShutdownz), eShut);
      check("R6", "phyRstz", int'(phyRstz), eRstz);
      check("R6", "ctrlRstN", (ctrlRstN == '1) ? 1 : ((ctrlRstN == '0) ? 0 : 2), eCtrl);
      check("R7", "ready", int'(ready), eReady);
      check("R8", "rangeErr", int'(rangeErr), eErr);
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic runSeq(int rate, int lanes, int dly);
    int n = 0;
    ackDelay = dly;
    rateMbps = 11'(rate);
    laneCount = 3'(lanes);
    startReq = 1'b1;
    tick();
    startReq = 1'b0;
    while (!ready && n < 20000) begin tick(); n++; end
    check("R7", "ready after sequence", int'(ready), 1);
    check("R8", "rangeErr for rate", int'(rangeErr), (rate < 80 || rate > 1500) ? 1 : 0);
    check("R2", "laneCfg after sequence", int'(laneCfg), lanes - 1);
    repeat (3) tick();
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (4) tick();
    // R1 reset values
    check("R1", "phyRstz", int'(phyRstz), 0);
    check("R1", "phyShutdownz", int'(phyShutdownz), 0);
    check("R1", "testClr", int'(testClr), 0);
    check("R1", "txnReq", int'(txnReq), 0);
    check("R1", "ready", int'(ready), 0);
    check("R1", "laneCfg", int'(laneCfg), 0);
    check("R1", "ctrlRstN", (ctrlRstN == '0) ? 0 : 1, 0);
    rstN = 1'b1;
    cmpOn = 1;
    tick();

    // R10: stop and start together in idle, stop wins
    rateMbps = 11'd500; laneCount = 3'd3;
    startReq = 1'b1; stopReq = 1'b1;
    tick();
    startReq = 1'b0; stopReq = 1'b0;
    repeat (3) tick();
    check("R10", "laneCfg after start+stop", int'(laneCfg), 0);
    check("R10", "testClr after start+stop", int'(testClr), 0);

    runSeq(1500, 4, 0);

    // R9: second start during the sequence is ignored
    ackDelay = 4; rateMbps = 11'd999; laneCount = 3'd3;
    startReq = 1'b1; tick(); startReq = 1'b0;
    repeat (50) tick();
    rateMbps = 11'd89; laneCount = 3'd1;
    startReq = 1'b1; tick(); startReq = 1'b0;
    repeat (2) tick();
    check("R9", "laneCfg after ignored start", int'(laneCfg), 2);
    check("R9", "testClr after ignored start", int'(testClr), 1);
    while (!ready) tick();
    check("R9", "rangeErr after ignored start", int'(rangeErr), 0);

    runSeq(89, 1, 2);
    runSeq(109, 3, 1);
    runSeq(449, 2, 0);
    runSeq(50, 1, 1);
    runSeq(2000, 4, 0);
    runSeq(80, 2, 0);
    runSeq(1501, 1, 0);

    // R10: stop from ready
    stopReq = 1'b1; tick(); stopReq = 1'b0;
    check("R10", "ready after stop", int'(ready), 0);
    check("R10", "laneCfg after stop", int'(laneCfg), 0);
    check("R10", "ctrlRstN after stop", (ctrlRstN == '0) ? 0 : 1, 0);

    // R10: stop during the clear pulse
    ackDelay = 0; rateMbps = 11'd129; laneCount = 3'd2;
    startReq = 1'b1; tick(); startReq = 1'b0;
    repeat (100) tick();
    stopReq = 1'b1; tick(); stopReq = 1'b0;
    check("R10", "testClr after stop mid-clear", int'(testClr), 0);
    repeat (20) tick();
    check("R10", "testClr stays low", int'(testClr), 0);

    // R10: stop in the same cycle as the acknowledge
    ackDelay = 0; rateMbps = 11'd999; laneCount = 3'd4;
    startReq = 1'b1; tick(); startReq = 1'b0;
    while (!txnReq) tick();
    stopReq = 1'b1; tick(); stopReq = 1'b0;
    check("R10", "txnReq after stop with ack", int'(txnReq), 0);
    repeat (1200) tick();
    check("R10", "shutdown held after stop with ack", int'(phyShutdownz), 0);

    runSeq(129, 2, 3);
    finish();
  end

endmodule